// File: doc/BRIEF.md
# Sequenced Four-Point FFT Engine

This block computes the forward discrete Fourier transform of four complex fixed-point samples using a radix-2 decimation-in-time structure. Both butterfly stages are separate parallel hardware. A small controller runs the datapath in a fixed order: it latches the samples, requests the two stage-two twiddle factors, loads stage one, then stage two, then the output register, and finally raises a one-cycle completion pulse.

The twiddle factors are not stored inside the block. Each one is requested by an angle index over a request/valid port and arrives as a pair of signed cosine and sine words. The word source is a rotation-based (shift-and-add) generator elsewhere on the chip, or the testbench. Each complex twiddle product is built from four real products of the data with the supplied cosine and sine, followed by one add and one subtract.

Controller states and transitions: IDLE goes to FETCH when start is high. FETCH stays while twiddles are outstanding and goes to STAGE1 when the twiddle with index 1 is accepted. STAGE1 goes to STAGE2, STAGE2 goes to OUT, and OUT goes back to IDLE. Every transition after FETCH is unconditional.

Top module: `fft4_seq`

## Requirements
- R1: After reset, `done` and `tw_req` are 0 and every bin output is 0.
- R2: `start` is sampled only in IDLE, where it latches all eight sample words. A `start` during a run is ignored: the bins of that run come from the samples latched first, and the run produces exactly one `done` pulse.
- R3: In FETCH, `tw_req` is high and `tw_idx` first presents 0 and then 1. Each index is held stable until a clock edge that sees `tw_valid` high. Index m means angle θ = 2π·m/4. `tw_cos` and `tw_sin` are signed words with 14 fraction bits (16384 = 1.0), and the factor used is cosθ − j·sinθ.
- R4: `done` is first high in the cycle that follows the third rising edge after the edge that accepts the index-1 twiddle.
- R5: `done` is high for exactly one clock cycle per run.
- R6: When the twiddles are correct, the bins are X[k] = Σ x[n]·e^(−j2πnk/4) in natural order k = 0..3, within ±2 LSB. Samples are packed with sample n (or bin k) in bits [16n+15:16n] (for bins, [18k+17:18k]).
- R7: The bins are 18-bit signed and do not overflow for any 16-bit input, including all samples at −32768 or at +32767.
- R8: The bin outputs hold their value until the next run reaches OUT.
- R9: The supplied twiddle words are used as given. With A0 = x0+x2, A1 = x0−x2, B0 = x1+x3 and B1 = x1−x3, and (c,s) the words accepted for index k: T = floor((Br·c + Bi·s + 8192)/16384) + j·floor((Bi·c − Br·s + 8192)/16384) is computed from Bk, X[k] = Ak + T and X[k+2] = Ak − T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (sampled in IDLE only) |
| smp_re | input | 64 | Real parts of the four samples, sample n at [16n+15:16n] |
| smp_im | input | 64 | Imaginary parts of the four samples |
| tw_req | output | 1 | Twiddle request, high in FETCH |
| tw_idx | output | 2 | Angle index of the requested twiddle |
| tw_valid | input | 1 | Twiddle words valid for the current index |
| tw_cos | input | 16 | Cosine word, signed, 14 fraction bits |
| tw_sin | input | 16 | Sine word, signed, 14 fraction bits |
| bin_re | output | 72 | Real parts of the bins, bin k at [18k+17:18k] |
| bin_im | output | 72 | Imaginary parts of the bins |
| done | output | 1 | One-cycle pulse when the bins are updated |

## Verification
Impulses at each of the four positions are used to check that every sample index reaches every bin with the correct rotation sign. This separates a swapped stage-one pairing or a mirrored bin order from a correct one. Constant, alternating and all-extreme vectors load the DC and Nyquist bins to full scale to check the growth bits, and random vectors with a varying twiddle latency cover the general case. Some runs supply a deliberately different index-1 twiddle, which separates a datapath that really uses the port words from one with a built-in rotation. Others pulse start during FETCH to show that this start is ignored.

// File: rtl/fft4_pkg.sv
package fft4_pkg;

    localparam int NPTS = 4;
    localparam int IDXW = $clog2(NPTS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_STAGE1,
        ST_STAGE2,
        ST_OUT
    } fft_state_e;

endpackage

// File: rtl/fft4_ctrl.sv
module fft4_ctrl
    import fft4_pkg::*;
#(
    parameter int NTW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            tw_valid,
    output logic            tw_req,
    output logic [IDXW-1:0] tw_idx,
    output logic            cap_en,
    output logic            tw_wr,
    output logic            s1_en,
    output logic            s2_en,
    output logic            out_en,
    output logic            done
);

    fft_state_e      state, nxt;
    logic [IDXW-1:0] tw_cnt;
    logic            last_tw;

    assign last_tw = (tw_cnt == IDXW'(NTW - 1));

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (start) nxt = ST_FETCH;
            ST_FETCH:  if (tw_valid && last_tw) nxt = ST_STAGE1;
            ST_STAGE1: nxt = ST_STAGE2;
            ST_STAGE2: nxt = ST_OUT;
            ST_OUT:    nxt = ST_IDLE;
            default:   nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            tw_cnt <= '0;
            done   <= 1'b0;
        end else begin
            state <= nxt;
            done  <= (state == ST_OUT);
            if (state == ST_FETCH && tw_valid)
                tw_cnt <= last_tw ? '0 : tw_cnt + 1'b1;
        end
    end

    always_comb begin
        tw_req = 1'b0;
        tw_wr  = 1'b0;
        cap_en = 1'b0;
        s1_en  = 1'b0;
        s2_en  = 1'b0;
        out_en = 1'b0;
        tw_idx = tw_cnt;
        unique case (state)
            ST_IDLE:   cap_en = start;
            ST_FETCH: begin
                tw_req = 1'b1;
                tw_wr  = tw_valid;
            end
            ST_STAGE1: s1_en  = 1'b1;
            ST_STAGE2: s2_en  = 1'b1;
            ST_OUT:    out_en = 1'b1;
            default: ;
        endcase
    end

    // R3
    tw_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tw_req && !tw_valid) |=> (tw_req && $stable(tw_idx)));

    // R4
    done_after_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(state == ST_OUT));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_STAGE1, ST_STAGE2, ST_OUT}) |=> (state != ST_FETCH));

endmodule

// File: rtl/fft4_bfly.sv
module fft4_bfly #(
    parameter int IW = 16
) (
    input  logic signed [IW-1:0] a_re,
    input  logic signed [IW-1:0] a_im,
    input  logic signed [IW-1:0] b_re,
    input  logic signed [IW-1:0] b_im,
    output logic signed [IW:0]   s_re,
    output logic signed [IW:0]   s_im,
    output logic signed [IW:0]   d_re,
    output logic signed [IW:0]   d_im
);

    localparam int SW = IW + 1;

    assign s_re = SW'(a_re) + SW'(b_re);
    assign s_im = SW'(a_im) + SW'(b_im);
    assign d_re = SW'(a_re) - SW'(b_re);
    assign d_im = SW'(a_im) - SW'(b_im);

endmodule

// File: rtl/fft4_twmul.sv
module fft4_twmul #(
    parameter int IW   = 17,
    parameter int CW   = 16,
    parameter int FRAC = 14,
    parameter int OUTW = 18
) (
    input  logic signed [IW-1:0]   d_re,
    input  logic signed [IW-1:0]   d_im,
    input  logic signed [CW-1:0]   c,
    input  logic signed [CW-1:0]   s,
    output logic signed [OUTW-1:0] p_re,
    output logic signed [OUTW-1:0] p_im
);

    localparam int PW = IW + CW + 1;
    localparam logic signed [PW-1:0] HALF = PW'(2 ** (FRAC - 1));

    logic signed [PW-1:0] re_full, im_full;

    // (d_re + j d_im)(c - j s) = (d_re c + d_im s) + j(d_im c - d_re s)
    always_comb begin
        re_full = PW'(d_re) * PW'(c) + PW'(d_im) * PW'(s) + HALF;
        im_full = PW'(d_im) * PW'(c) - PW'(d_re) * PW'(s) + HALF;
        p_re    = OUTW'(re_full >>> FRAC);
        p_im    = OUTW'(im_full >>> FRAC);
    end

endmodule

// File: rtl/fft4_seq.sv
module fft4_seq
    import fft4_pkg::*;
#(
    parameter int DW    = 16,
    parameter int TW    = 16,
    parameter int TFRAC = 14
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [NPTS*DW-1:0]       smp_re,
    input  logic [NPTS*DW-1:0]       smp_im,
    output logic                     tw_req,
    output logic [IDXW-1:0]          tw_idx,
    input  logic                     tw_valid,
    input  logic [TW-1:0]            tw_cos,
    input  logic [TW-1:0]            tw_sin,
    output logic [NPTS*(DW+2)-1:0]   bin_re,
    output logic [NPTS*(DW+2)-1:0]   bin_im,
    output logic                     done
);

    localparam int S1W  = DW + 1;
    localparam int OW   = DW + 2;
    localparam int HALF = NPTS / 2;
    localparam int NTW  = NPTS / 2;

    logic cap_en, tw_wr, s1_en, s2_en, out_en;

    logic signed [DW-1:0]  in_re_q  [NPTS];
    logic signed [DW-1:0]  in_im_q  [NPTS];
    logic signed [S1W-1:0] s1_re_w  [NPTS];
    logic signed [S1W-1:0] s1_im_w  [NPTS];
    logic signed [S1W-1:0] s1_re_q  [NPTS];
    logic signed [S1W-1:0] s1_im_q  [NPTS];
    logic signed [OW:0]    s2_re_w  [NPTS];
    logic signed [OW:0]    s2_im_w  [NPTS];
    logic signed [OW-1:0]  s2_re_q  [NPTS];
    logic signed [OW-1:0]  s2_im_q  [NPTS];
    logic signed [OW-1:0]  out_re_q [NPTS];
    logic signed [OW-1:0]  out_im_q [NPTS];
    logic signed [TW-1:0]  twc_q    [NTW];
    logic signed [TW-1:0]  tws_q    [NTW];

    fft4_ctrl #(.NTW(NTW)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .tw_valid (tw_valid),
        .tw_req   (tw_req),
        .tw_idx   (tw_idx),
        .cap_en   (cap_en),
        .tw_wr    (tw_wr),
        .s1_en    (s1_en),
        .s2_en    (s2_en),
        .out_en   (out_en),
        .done     (done)
    );

    // Stage 1: pairs sample g with sample g+2; sum to slot 2g, difference to 2g+1.
    for (genvar g = 0; g < HALF; g++) begin : g_s1
        fft4_bfly #(.IW(DW)) u_bf1 (
            .a_re (in_re_q[g]),
            .a_im (in_im_q[g]),
            .b_re (in_re_q[g+HALF]),
            .b_im (in_im_q[g+HALF]),
            .s_re (s1_re_w[2*g]),
            .s_im (s1_im_w[2*g]),
            .d_re (s1_re_w[2*g+1]),
            .d_im (s1_im_w[2*g+1])
        );
    end

    // Stage 2: slot k against twiddled slot k+2; bins k and k+2.
    for (genvar k = 0; k < HALF; k++) begin : g_s2
        logic signed [OW-1:0] top_re, top_im, rot_re, rot_im;

        assign top_re = OW'(s1_re_q[k]);
        assign top_im = OW'(s1_im_q[k]);

        fft4_twmul #(.IW(S1W), .CW(TW), .FRAC(TFRAC), .OUTW(OW)) u_tm (
            .d_re (s1_re_q[k+HALF]),
            .d_im (s1_im_q[k+HALF]),
            .c    (twc_q[k]),
            .s    (tws_q[k]),
            .p_re (rot_re),
            .p_im (rot_im)
        );

        fft4_bfly #(.IW(OW)) u_bf2 (
            .a_re (top_re),
            .a_im (top_im),
            .b_re (rot_re),
            .b_im (rot_im),
            .s_re (s2_re_w[k]),
            .s_im (s2_im_w[k]),
            .d_re (s2_re_w[k+HALF]),
            .d_im (s2_im_w[k+HALF])
        );

        // R7
        no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            s2_en |-> (s2_re_w[k][OW] == s2_re_w[k][OW-1]) &&
                      (s2_im_w[k][OW] == s2_im_w[k][OW-1]) &&
                      (s2_re_w[k+HALF][OW] == s2_re_w[k+HALF][OW-1]) &&
                      (s2_im_w[k+HALF][OW] == s2_im_w[k+HALF][OW-1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPTS; i++) begin
                in_re_q[i]  <= '0;
                in_im_q[i]  <= '0;
                s1_re_q[i]  <= '0;
                s1_im_q[i]  <= '0;
                s2_re_q[i]  <= '0;
                s2_im_q[i]  <= '0;
                out_re_q[i] <= '0;
                out_im_q[i] <= '0;
            end
            for (int t = 0; t < NTW; t++) begin
                twc_q[t] <= '0;
                tws_q[t] <= '0;
            end
        end else begin
            for (int i = 0; i < NPTS; i++) begin
                if (cap_en) begin
                    in_re_q[i] <= $signed(smp_re[i*DW +: DW]);
                    in_im_q[i] <= $signed(smp_im[i*DW +: DW]);
                end
                if (s1_en) begin
                    s1_re_q[i] <= s1_re_w[i];
                    s1_im_q[i] <= s1_im_w[i];
                end
                if (s2_en) begin
                    s2_re_q[i] <= OW'(s2_re_w[i]);
                    s2_im_q[i] <= OW'(s2_im_w[i]);
                end
                if (out_en) begin
                    out_re_q[i] <= s2_re_q[i];
                    out_im_q[i] <= s2_im_q[i];
                end
            end
            for (int t = 0; t < NTW; t++) begin
                if (tw_wr && tw_idx == IDXW'(t)) begin
                    twc_q[t] <= $signed(tw_cos);
                    tws_q[t] <= $signed(tw_sin);
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < NPTS; i++) begin
            bin_re[i*OW +: OW] = out_re_q[i];
            bin_im[i*OW +: OW] = out_im_q[i];
        end
    end

    // R8
    bins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> $stable(bin_re) && $stable(bin_im));

endmodule

// File: tb/fft4_seq_bench.sv
`timescale 1ns/1ps
module fft4_seq_bench;

    localparam int OW = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        tw_valid = 1'b0;
    logic [15:0] tw_cos = '0;
    logic [15:0] tw_sin = '0;
    logic [63:0] smp_re = '0;
    logic [63:0] smp_im = '0;
    logic        tw_req;
    logic [1:0]  tw_idx;
    logic [71:0] bin_re, bin_im;
    logic        done;

    int n_chk = 0, n_err = 0;
    int cyc = 0, acc_cyc = -1, done_cyc = -1, done_cnt = 0;
    int tw_mode = 0, tw_lat = 0, acc_n = 0, wcnt = 0;
    logic [1:0] held = '0;
    bit finished = 1'b0;
    int xr[4], xi[4], er[4], ei[4];

    always #2.5 clk = ~clk;

    fft4_seq u_fft4_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .smp_re   (smp_re),
        .smp_im   (smp_im),
        .tw_req   (tw_req),
        .tw_idx   (tw_idx),
        .tw_valid (tw_valid),
        .tw_cos   (tw_cos),
        .tw_sin   (tw_sin),
        .bin_re   (bin_re),
        .bin_im   (bin_im),
        .done     (done)
    );

    task automatic chk(input string req, input int act, input int exp, input int tol);
        int diff;
        n_chk++;
        diff = act - exp;
        if (diff > tol || diff < -tol) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Twiddle words for index idx: mode 0 exact quarter angles, mode 1 flips index-1 sine.
    function automatic void tw_table(input int mode, input int idx, output int c, output int s);
        c = (idx == 0) ? 16384 : 0;
        s = (idx == 0) ? 0 : 16384;
        if (mode == 1 && idx == 1) s = -16384;
    endfunction

    // Twiddle source and done monitor, all on the falling edge.
    initial begin
        int c, s;
        forever begin
            @(negedge clk);
            cyc++;
            if (done) begin
                done_cnt++;
                if (done_cyc < 0) done_cyc = cyc;
            end
            if (tw_valid) begin
                tw_valid = 1'b0;
                wcnt = 0;
            end else if (tw_req) begin
                if (wcnt > 0) chk("R3 index held", int'(tw_idx), int'(held), 0);
                held = tw_idx;
                if (wcnt >= tw_lat) begin
                    chk("R3 index order", int'(tw_idx), acc_n, 0);
                    tw_table(tw_mode, int'(tw_idx), c, s);
                    tw_cos = 16'(c);
                    tw_sin = 16'(s);
                    tw_valid = 1'b1;
                    if (tw_idx == 2'd1) acc_cyc = cyc;
                    acc_n++;
                end else begin
                    wcnt++;
                end
            end
        end
    end

    task automatic calc_exp(input int mode);
        longint ar[2], ai[2], br[2], bi[2], tr, ti;
        int c, s;
        for (int k = 0; k < 4; k++) begin
            er[k] = 0;
            ei[k] = 0;
        end
        if (mode == 0) begin
            for (int k = 0; k < 4; k++)
                for (int n = 0; n < 4; n++)
                    case ((n * k) % 4)
                        0: begin er[k] += xr[n]; ei[k] += xi[n]; end
                        1: begin er[k] += xi[n]; ei[k] -= xr[n]; end
                        2: begin er[k] -= xr[n]; ei[k] -= xi[n]; end
                        default: begin er[k] -= xi[n]; ei[k] += xr[n]; end
                    endcase
        end else begin
            ar[0] = xr[0] + xr[2]; ai[0] = xi[0] + xi[2];
            ar[1] = xr[0] - xr[2]; ai[1] = xi[0] - xi[2];
            br[0] = xr[1] + xr[3]; bi[0] = xi[1] + xi[3];
            br[1] = xr[1] - xr[3]; bi[1] = xi[1] - xi[3];
            for (int k = 0; k < 2; k++) begin
                tw_table(mode, k, c, s);
                tr = (br[k] * c + bi[k] * s + 8192) >>> 14;
                ti = (bi[k] * c - br[k] * s + 8192) >>> 14;
                er[k]   = int'(ar[k] + tr);
                ei[k]   = int'(ai[k] + ti);
                er[k+2] = int'(ar[k] - tr);
                ei[k+2] = int'(ai[k] - ti);
            end
        end
    endtask

    task automatic chk_bins(input string req);
        for (int k = 0; k < 4; k++) begin
            chk(req, int'($signed(bin_re[k*OW +: OW])), er[k], 2);
            chk(req, int'($signed(bin_im[k*OW +: OW])), ei[k], 2);
        end
    endtask

    task automatic run(input int mode, input int lat, input bit inject, input string tag);
        int prev;
        tw_mode  = mode;
        tw_lat   = lat;
        acc_n    = 0;
        acc_cyc  = -1;
        done_cyc = -1;
        prev     = done_cnt;
        @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            smp_re[k*16 +: 16] = 16'(xr[k]);
            smp_im[k*16 +: 16] = 16'(xi[k]);
        end
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            @(negedge clk);
            smp_re = ~smp_re;
            smp_im = smp_im ^ 64'h5a5a_1234_a5a5_4321;
            start  = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        calc_exp(mode);
        while (done_cnt == prev) @(negedge clk);
        chk_bins(tag);
        chk("R4 latency from last twiddle", done_cyc - acc_cyc, 4, 0);
        repeat (6) @(negedge clk);
        chk(inject ? "R2 single done despite extra start" : "R5 single done", done_cnt - prev, 1, 0);
        chk_bins("R8 hold");
    endtask

    task automatic set_all(input int r, input int i);
        for (int k = 0; k < 4; k++) begin
            xr[k] = r;
            xi[k] = i;
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 done", int'(done), 0, 0);
        chk("R1 tw_req", int'(tw_req), 0, 0);
        chk("R1 bins re", int'(bin_re != '0), 0, 0);
        chk("R1 bins im", int'(bin_im != '0), 0, 0);

        // R6 impulses at every position, both extremes
        for (int p = 0; p < 4; p++) begin
            for (int a = 0; a < 2; a++) begin
                set_all(0, 0);
                xr[p] = (a == 0) ? 32767 : -32768;
                xi[p] = (a == 0) ? -1234 : 32767;
                run(0, p, 1'b0, "R6 impulse");
            end
        end

        // R7 full-scale constants and alternations
        set_all(32767, 32767);    run(0, 1, 1'b0, "R7 max constant");
        set_all(-32768, -32768);  run(0, 2, 1'b0, "R7 min constant");
        xr = '{32767, -32768, 32767, -32768};
        xi = '{-32768, 32767, -32768, 32767};
        run(0, 0, 1'b0, "R7 alternating");
        xr = '{-32768, 32767, 32767, -32768};
        xi = '{32767, 32767, -32768, -32768};
        run(0, 3, 1'b0, "R7 quadrature");

        // R9 twiddle words taken from the port
        xr = '{100, -2000, 3000, 32767};
        xi = '{-500, 700, -32768, 1};
        run(1, 1, 1'b0, "R9 supplied twiddle");
        set_all(0, 0);
        xr[1] = 32767; xi[3] = -32768;
        run(1, 0, 1'b0, "R9 supplied twiddle");

        // R2 start during a run
        xr = '{11, 22, 33, 44};
        xi = '{-5, 6, -7, 8};
        run(0, 3, 1'b1, "R2 ignored start");

        // Random sweep
        for (int r = 0; r < 150; r++) begin
            for (int k = 0; k < 4; k++) begin
                xr[k] = int'($urandom % 65536) - 32768;
                xi[k] = int'($urandom % 65536) - 32768;
            end
            run((r % 10 == 3) ? 1 : 0, (r % 5 == 4) ? 3 : r % 4, r % 5 == 4,
                (r % 10 == 3) ? "R9 random" : "R6 random");
        end

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

endmodule